// File: doc/BRIEF.md
# SPI Master with Two-Stage Bit-Rate Divider

This block is a serial peripheral master that exchanges 8-bit frames with an external device in clock mode 0. The serial clock is low while idle. Input data is sampled on the rising edge and output data changes on the falling edge. Each frame shifts one byte out on `mosi` and, at the same time, collects one byte from `miso`. The chip select output `cs_n` is active low.

The serial clock comes from two counters in series that run on the module clock. The first counter divides by half of an even prescale value. The odd bit of the prescale input is discarded. The second counter divides that result by one plus a rate value. Because each half of the serial clock period lasts the same whole number of module cycles, the serial clock always has an equal high and low time.

The bit rate is the module clock divided by `prescale * (1 + rate)`. The fastest setting is prescale 2 with rate 0, which gives half the module clock. The divider settings are captured when a frame starts. A hold option lets a waiting byte continue straight into a new frame without releasing chip select.

Top module: `spi_master2p`

## Requirements
- R1: Each half of the serial clock period lasts exactly (P/2)*(1+R) module clock cycles, where P is the effective prescale and R is the rate value. High and low times are therefore equal, and a frame keeps `cs_n` low for 16 such half-periods.
- R2: Bit 0 of `presc_val` is ignored, so an odd value acts as the next lower even value. Values 0 and 1 act as 2, which makes the effective prescale range 2 to 254.
- R3: `sclk` is low whenever `cs_n` is high, and after reset `sclk`=0, `cs_n`=1, `mosi`=0 and `rx_valid`=0. In a frame `sclk` starts low, and its first transition is a rising edge.
- R4: With a prescale of 2 and a rate of 0, `sclk` toggles on every module clock cycle, which is half the module clock.
- R5: Data goes out MSB first. Bit 7 appears on `mosi` in the same cycle that `cs_n` falls. During a frame, `mosi` changes only together with a falling edge of `sclk`.
- R6: If no further byte continues the frame, `cs_n` rises together with the eighth falling edge. It then stays high for at least one half-period before the next frame can start.
- R7: `tx_ready` is 1 while the block is idle. A byte is accepted on a clock edge where both `tx_valid` and `tx_ready` are 1, and that edge starts the frame.
- R8: `miso` is sampled on each rising edge of `sclk`, with the first sample placed in bit 7. `rx_valid` pulses for exactly one cycle, starting in the cycle where the eighth rising edge appears, and `rx_data` holds the byte from that cycle on.
- R9: `presc_val` and `rate_val` are captured when a byte is accepted. Changing them during a frame does not alter that frame's timing.
- R10: When `hold_en` is 1, `tx_ready` is also 1 in the last cycle of the eighth high phase. If `tx_valid` is 1 then, the new byte is accepted with freshly captured divider settings, and `cs_n` stays low with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_val | input | PW (8) | Prescale value; the odd bit is ignored |
| rate_val | input | RW (8) | Rate value, 0 to 255 |
| hold_en | input | 1 | Keep chip select low for back-to-back frames |
| tx_data | input | DW (8) | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block accepts a byte on this edge |
| rx_data | output | DW (8) | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` is new |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its default widths: an 8-bit prescale, an 8-bit rate and an 8-bit frame. With these widths the full divider range is reachable in a short run. This includes the fastest setting (prescale 2, rate 0, one cycle per half-period), the largest prescale of 254, and the largest rate of 255. Odd, zero and one prescale values test that the low bit is discarded. Back-to-back frames with hold, and setting changes in the middle of a frame, test the capture timing at frame boundaries against the bench's cycle-by-cycle model.

// File: rtl/spi_pkg.sv
package spi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } spi_state_e;
endpackage

// File: rtl/spi_baud_div.sv
// Two cascaded counters: a half-prescale stage and a rate stage.
// tick marks the last module cycle of a serial-clock half-period.
module spi_baud_div #(
    parameter int PW = 8,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [PW-1:0] presc_in,
    input  logic [RW-1:0] rate_in,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] half_m1;
        logic [RW-1:0] rate;
        logic [PW-1:0] pcnt;
        logic [RW-1:0] rcnt;
    } div_s;

    div_s st_d, st_q;
    logic [PW-1:0] half_w;

    always_comb begin
        st_d   = st_q;
        half_w = presc_in >> 1;
        tick   = run && (st_q.pcnt == st_q.half_m1) && (st_q.rcnt == st_q.rate);
        if (load) begin
            st_d.half_m1 = (half_w == '0) ? '0 : half_w - PW'(1);
            st_d.rate    = rate_in;
            st_d.pcnt    = '0;
            st_d.rcnt    = '0;
        end else if (run) begin
            if (st_q.pcnt == st_q.half_m1) begin
                st_d.pcnt = '0;
                if (st_q.rcnt == st_q.rate) st_d.rcnt = '0;
                else                        st_d.rcnt = st_q.rcnt + RW'(1);
            end else begin
                st_d.pcnt = st_q.pcnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_frame_ctl.sv
// Frame sequencer: chip select, mode-0 serial clock, shift registers.
module spi_frame_ctl #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hold_en,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    input  logic          miso,
    output logic          tx_ready,
    output logic          load,
    output logic          run,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid
);
    import spi_pkg::*;
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        spi_state_e    state;
        logic          sclk;
        logic          cs_n;
        logic [DW-1:0] tx_sh;
        logic [DW-2:0] rx_sh;
        logic [DW-1:0] rx_data;
        logic          rx_valid;
        logic [CW-1:0] bits;
    } ctl_s;

    ctl_s st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rx_valid = 1'b0;
        tx_ready      = 1'b0;
        load          = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                tx_ready = 1'b1;
                if (tx_valid) begin
                    load       = 1'b1;
                    st_d.state = ST_SHIFT;
                    st_d.cs_n  = 1'b0;
                    st_d.sclk  = 1'b0;
                    st_d.tx_sh = tx_data;
                    st_d.bits  = '0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!st_q.sclk) begin
                        st_d.sclk  = 1'b1;
                        st_d.rx_sh = {st_q.rx_sh[DW-3:0], miso};
                        st_d.bits  = st_q.bits + CW'(1);
                        if (st_q.bits == CW'(DW - 1)) begin
                            st_d.rx_data  = {st_q.rx_sh, miso};
                            st_d.rx_valid = 1'b1;
                        end
                    end else begin
                        st_d.sclk = 1'b0;
                        if (st_q.bits == CW'(DW)) begin
                            tx_ready = hold_en;
                            if (hold_en && tx_valid) begin
                                load       = 1'b1;
                                st_d.tx_sh = tx_data;
                                st_d.bits  = '0;
                            end else begin
                                st_d.state = ST_GAP;
                                st_d.cs_n  = 1'b1;
                            end
                        end else begin
                            st_d.tx_sh = st_q.tx_sh << 1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.cs_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run      = (st_q.state != ST_IDLE);
    assign sclk     = st_q.sclk;
    assign cs_n     = st_q.cs_n;
    assign mosi     = st_q.tx_sh[DW-1];
    assign rx_data  = st_q.rx_data;
    assign rx_valid = st_q.rx_valid;
endmodule

// File: rtl/spi_master2p.sv
module spi_master2p #(
    parameter int PW = 8,
    parameter int RW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] presc_val,
    input  logic [RW-1:0] rate_val,
    input  logic          hold_en,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);
    logic tick, load, run;

    spi_baud_div #(.PW(PW), .RW(RW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .run      (run),
        .presc_in (presc_val),
        .rate_in  (rate_val),
        .tick     (tick)
    );

    spi_frame_ctl #(.DW(DW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold_en  (hold_en),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .miso     (miso),
        .tx_ready (tx_ready),
        .load     (load),
        .run      (run),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/spi_master2p_chk.sv
module spi_master2p_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic rx_valid,
    input logic tx_valid,
    input logic tx_ready
);
    logic        sclk_p, cs_p;
    logic [31:0] hi_len, lo_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= 1'b0;
            cs_p   <= 1'b1;
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            sclk_p <= sclk;
            cs_p   <= cs_n;
            if (sclk) hi_len <= sclk_p ? hi_len + 32'd1 : 32'd1;
            else      lo_len <= (sclk_p || (cs_p && !cs_n)) ? 32'd1 : lo_len + 32'd1;
        end
    end

    // R1: the high phase that ends now is as long as the low phase before it
    a_r1_equal_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && sclk_p) |-> (hi_len == lo_len));

    a_r3_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r5_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi));

    a_r6_cs_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && cs_n) |=> !cs_n);

    a_r8_rxv_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r8_rxv_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $rose(sclk));
endmodule

bind spi_master2p spi_master2p_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready)
);

// File: tb/spi_master2p_tb.sv
`timescale 1ns/1ps
module spi_master2p_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] presc_val = 8'd2, rate_val = 8'd0, tx_data = 8'd0;
    logic       hold_en = 1'b0, tx_valid = 1'b0, miso = 1'b0;
    logic       tx_ready, rx_valid, sclk, mosi, cs_n;
    logic [7:0] rx_data;

    int n_chk = 0, n_fail = 0, cycles = 0;

    always #2.5 clk = ~clk;

    spi_master2p u_dut (
        .clk(clk), .rst_n(rst_n), .presc_val(presc_val), .rate_val(rate_val),
        .hold_en(hold_en), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // random serial input, changed just after each rising clock edge
    always @(posedge clk) miso <= #1 1'($urandom % 2);

    // behavioural reference: one countdown per half-period
    int   m_st, m_cnt, m_H, m_bits;
    bit   m_sclk, m_cs_n, m_mosi, m_rxv;
    logic [7:0] m_tx, m_rx, m_rxd;

    function automatic int half_len(input logic [7:0] p, input logic [7:0] r);
        int h = int'(p) / 2;
        if (h == 0) h = 1;
        return h * (int'(r) + 1);
    endfunction

    function automatic bit m_ready();
        return (m_st == 0) ||
               (m_st == 1 && m_cnt == m_H - 1 && m_sclk && m_bits == 8 && hold_en);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_H = 1; m_bits = 0;
            m_sclk = 0; m_cs_n = 1; m_mosi = 0; m_rxv = 0;
            m_tx = 0; m_rx = 0; m_rxd = 0;
        end else begin
            m_rxv = 0;
            case (m_st)
                0: if (tx_valid) begin
                    m_H = half_len(presc_val, rate_val);
                    m_tx = tx_data; m_mosi = tx_data[7];
                    m_cs_n = 0; m_sclk = 0; m_bits = 0; m_cnt = 0; m_st = 1;
                end
                1: if (m_cnt == m_H - 1) begin
                    m_cnt = 0;
                    if (!m_sclk) begin
                        m_sclk = 1; m_rx = {m_rx[6:0], miso}; m_bits++;
                        if (m_bits == 8) begin m_rxd = m_rx; m_rxv = 1; end
                    end else begin
                        m_sclk = 0;
                        if (m_bits == 8) begin
                            if (hold_en && tx_valid) begin
                                m_H = half_len(presc_val, rate_val);
                                m_tx = tx_data; m_mosi = tx_data[7]; m_bits = 0;
                            end else begin
                                m_st = 2; m_cs_n = 1;
                            end
                        end else begin
                            m_tx = m_tx << 1; m_mosi = m_tx[7];
                        end
                    end
                end else m_cnt++;
                default: if (m_cnt == m_H - 1) begin m_cnt = 0; m_st = 0; end
                         else m_cnt++;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sclk == m_sclk, "R1 sclk", sclk, m_sclk);
            chk(cs_n == m_cs_n, "R6 cs_n", cs_n, m_cs_n);
            chk(mosi == m_mosi, "R5 mosi", mosi, m_mosi);
            chk(rx_valid == m_rxv, "R8 rx_valid", rx_valid, m_rxv);
            chk(rx_data == m_rxd, "R8 rx_data", rx_data, m_rxd);
            chk(tx_ready == m_ready(), "R7 tx_ready", tx_ready, m_ready());
            if (cs_n) chk(!sclk, "R3 sclk idle low", sclk, 0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            report();
        end
    end

    task automatic accept(input logic [7:0] d, input logic [7:0] p, input logic [7:0] r);
        @(posedge clk); #1;
        presc_val = p; rate_val = r; tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    // measures cs low time and the bits on mosi at each rising sclk edge
    task automatic finish_frame(input logic [7:0] exp_d, input int h, input string req);
        int n = 0;
        bit prev = 0;
        logic [7:0] got = '0;
        int first_rise = -1;
        @(negedge clk);
        while (!cs_n) begin
            n++;
            if (sclk && !prev) begin
                got = {got[6:0], mosi};
                if (first_rise < 0) first_rise = n;
            end
            prev = sclk;
            @(negedge clk);
        end
        chk(n == 16 * h, {req, " frame length"}, n, 16 * h);
        chk(first_rise == h + 1, {req, " first rise"}, first_rise, h + 1);
        chk(got == exp_d, "R5 msb first", got, exp_d);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        chk(cs_n == 1'b1, "R3 reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R3 reset sclk", sclk, 0);
        chk(mosi == 1'b0, "R3 reset mosi", mosi, 0);
        chk(rx_valid == 1'b0, "R3 reset rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b1, "R7 idle ready", tx_ready, 1);

        // R4: fastest setting
        accept(8'hA5, 8'd2, 8'd0);
        finish_frame(8'hA5, 1, "R4");
        accept(8'h3C, 8'd6, 8'd2);
        finish_frame(8'h3C, 9, "R1");
        // R2: odd prescale acts as next lower even, 0 and 1 act as 2
        accept(8'h81, 8'd7, 8'd1);
        finish_frame(8'h81, 6, "R2 odd");
        accept(8'h5A, 8'd1, 8'd0);
        finish_frame(8'h5A, 1, "R2 one");
        accept(8'hC3, 8'd0, 8'd1);
        finish_frame(8'hC3, 2, "R2 zero");
        // R9: settings changed mid-frame are ignored for this frame
        accept(8'h96, 8'd4, 8'd1);
        presc_val = 8'd20; rate_val = 8'd5;
        finish_frame(8'h96, 4, "R9");
        // extremes of both stages
        accept(8'hF0, 8'd255, 8'd3);
        finish_frame(8'hF0, 508, "R2 max prescale");
        accept(8'h0F, 8'd2, 8'd255);
        finish_frame(8'h0F, 256, "R1 max rate");

        // R10: back-to-back frames with hold keep cs low
        hold_en = 1'b1;
        accept(8'h12, 8'd4, 8'd0);
        tx_data = 8'hED; tx_valid = 1'b1; presc_val = 8'd8; rate_val = 8'd0;
        begin
            int hi_seen = 0;
            @(negedge clk);
            while (!tx_ready) begin
                if (cs_n) hi_seen++;
                @(negedge clk);
            end
            chk(hi_seen == 0, "R10 cs held", hi_seen, 0);
        end
        @(posedge clk); #1;
        tx_valid = 1'b0;
        finish_frame(8'hED, 4, "R10");
        // hold set but nothing waiting: frame ends normally
        accept(8'h66, 8'd2, 8'd1);
        finish_frame(8'h66, 2, "R6");
        hold_en = 1'b0;
        repeat (10) @(posedge clk);
        report();
    end
endmodule